// File: doc/BRIEF.md
# Register Rename Stage with Self-Zeroing Elimination

This block renames a group of up to four decoded micro-ops per cycle for a small out-of-order core. Each lane carries an operation class, two architectural source registers and one architectural destination. The stage reads a rename table to turn the sources into physical tags and takes fresh physical destinations from a free list. It writes each renamed group into an output register that feeds the issue logic.

Micro-ops that always yield zero are handled here and never reach an execution unit. These are an exclusive-or or a subtraction of a register with itself. The stage points the destination at physical register 0, a hardwired zero register that is never allocated, and marks the lane as eliminated. A self compare-equal always produces all ones. It drops its source dependency but still takes a physical register and still executes.

Input and output are valid/ready streams carrying whole groups. A group is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends on the presented lanes and on the output register, so a source must hold a presented group stable until it is taken. The output holds its group while `out_valid` is high and `out_ready` is low. Displaced physical tags are reported with each output lane. The retire logic hands them back on the release ports.

Top module: `rename_zero_stage`

## Requirements
- R1: After reset `out_valid` is 0. Architectural register i maps to physical register i+1. The free list holds physical registers ARCH_REGS+1 up to PHYS_REGS-1. `in_ready` is 1 when no lane is presented.
- R2: Operation class codes are 0 add, 1 subtract, 2 exclusive-or and 3 compare-equal. A valid lane with code 1 or 2 and equal sources is eliminated. Its output has `out_elim`=1, destination tag 0 and both source tags 0, and it takes no register from the free list.
- R3: An add (code 0) with equal sources is not special. Both source tags are the current mapping of that register, and it takes a fresh destination with `out_elim`=0.
- R4: A compare-equal (code 3) with equal sources has both source tags 0. It still takes a fresh destination, with `out_elim`=0.
- R5: Fresh destinations are the lowest-numbered free physical registers, handed out in lane order from lane 0. Physical register 0 is never handed out.
- R6: A lane's sources see the destinations written by earlier lanes of the same group, including a remap to register 0.
- R7: Each valid lane reports the mapping its destination had before it was renamed, in `out_pold`. `out_pold_vld` is 1 exactly when that tag is not 0, so the zero register is never reported for freeing.
- R8: If the free list holds fewer registers than the group's non-eliminated valid lanes need, `in_ready` is 0. The rename table and the free list are then left unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output group stays stable and `in_ready` is 0.
- R10: A tag on a release lane with `rel_vld` set is free from the next cycle on. A release of tag 0 is ignored.
- R11: A lane presented with its lane-valid bit at 0 comes out with `out_lane_vld` at 0. It takes no register and changes no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input group is presented |
| in_ready | output | 1 | Stage takes the presented group |
| in_lane_vld | input | LANES | Per-lane valid |
| in_op | input | 2*LANES | Operation class per lane |
| in_src1 | input | AW*LANES | First architectural source per lane |
| in_src2 | input | AW*LANES | Second architectural source per lane |
| in_dst | input | AW*LANES | Architectural destination per lane |
| out_valid | output | 1 | Output group is valid |
| out_ready | input | 1 | Downstream takes the output group |
| out_lane_vld | output | LANES | Per-lane valid |
| out_elim | output | LANES | Lane completed at rename, not to be executed |
| out_psrc1 | output | PW*LANES | First physical source tag |
| out_psrc2 | output | PW*LANES | Second physical source tag |
| out_pdst | output | PW*LANES | Physical destination tag |
| out_pold | output | PW*LANES | Displaced physical tag |
| out_pold_vld | output | LANES | Displaced tag must be freed at retire |
| rel_vld | input | LANES | Release lane valid |
| rel_tag | input | PW*LANES | Physical tag returned to the free list |

## Verification
The assertions assume that the retire side releases only tags that were displaced and not yet returned, and never the same tag twice. If that holds, two live lanes can never share a destination tag. The bench keeps a queue of the displaced tags it has seen at the output and releases only entries from that queue, each once. The single extra release it makes is of tag 0, which the stage must ignore. The bench also holds every presented group stable until it is either taken or withdrawn at a cycle edge. This matches the input rule that the hold assertions rely on.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_XOR   = 2'd2,
    OPC_CMPEQ = 2'd3
  } opc_e;
endpackage

// File: rtl/rn_idiom.sv
module rn_idiom #(
  parameter int AW = 3
) (
  input  logic          vld,
  input  logic [1:0]    op,
  input  logic [AW-1:0] s1,
  input  logic [AW-1:0] s2,
  output logic          zero_idiom,
  output logic          dep_break,
  output logic          need_alloc
);
  import rn_pkg::*;
  opc_e opc;
  logic same;

  always_comb begin
    opc        = opc_e'(op);
    same       = (s1 == s2);
    // subtract or xor of a register with itself always gives zero
    zero_idiom = vld && same && (opc == OPC_SUB || opc == OPC_XOR);
    // any self operation except add ignores the source value
    dep_break  = vld && same && (opc != OPC_ADD);
    need_alloc = vld && !zero_idiom;
  end
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 24,
  parameter int LANES     = 4,
  parameter int PW        = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    need,
  input  logic                commit,
  input  logic [LANES-1:0]    rel_vld,
  input  logic [LANES*PW-1:0] rel_tag,
  output logic [LANES*PW-1:0] alloc_tag,
  output logic                alloc_ok
);
  logic [PHYS_REGS-1:0] free_q;
  logic [PHYS_REGS-1:0] avail;
  logic [PHYS_REGS-1:0] taken;
  logic [PHYS_REGS-1:0] rel_mask;
  logic                 found;
  logic [PW-1:0]        rt;

  // lowest free register goes to the lowest needing lane
  always_comb begin
    avail     = free_q;
    taken     = '0;
    alloc_tag = '0;
    alloc_ok  = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      found = 1'b0;
      if (need[l]) begin
        for (int p = 1; p < PHYS_REGS; p++) begin
          if (!found && avail[p]) begin
            found                   = 1'b1;
            alloc_tag[l*PW +: PW]   = PW'(p);
            avail[p]                = 1'b0;
            taken[p]                = 1'b1;
          end
        end
        if (!found) alloc_ok = 1'b0;
      end
    end
  end

  // returned tags; the zero register is never put back
  always_comb begin
    rel_mask = '0;
    rt       = '0;
    for (int l = 0; l < LANES; l++) begin
      rt = rel_tag[l*PW +: PW];
      if (rel_vld[l] && rt != '0 && int'(rt) < PHYS_REGS) rel_mask[rt] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PHYS_REGS; p++) free_q[p] <= (p > ARCH_REGS);
    end else begin
      free_q <= ((commit && alloc_ok) ? (free_q & ~taken) : free_q) | rel_mask;
    end
  end
endmodule

// File: rtl/rn_map.sv
module rn_map #(
  parameter int ARCH_REGS = 8,
  parameter int LANES     = 4,
  parameter int AW        = 3,
  parameter int PW        = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [LANES-1:0]    lane_vld,
  input  logic [LANES*AW-1:0] src1,
  input  logic [LANES*AW-1:0] src2,
  input  logic [LANES*AW-1:0] dst,
  input  logic [LANES-1:0]    zero_idiom,
  input  logic [LANES-1:0]    dep_break,
  input  logic [LANES*PW-1:0] alloc_tag,
  output logic [LANES*PW-1:0] psrc1,
  output logic [LANES*PW-1:0] psrc2,
  output logic [LANES*PW-1:0] pdst,
  output logic [LANES*PW-1:0] pold,
  output logic [LANES-1:0]    pold_vld
);
  logic [PW-1:0] map_q [ARCH_REGS];
  logic [PW-1:0] work  [ARCH_REGS];
  logic [AW-1:0] a1, a2, ad;
  logic [PW-1:0] nt;

  // lanes are walked in order so later lanes see earlier writes
  always_comb begin
    for (int a = 0; a < ARCH_REGS; a++) work[a] = map_q[a];
    psrc1 = '0; psrc2 = '0; pdst = '0; pold = '0; pold_vld = '0;
    a1 = '0; a2 = '0; ad = '0; nt = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld[l]) begin
        a1 = src1[l*AW +: AW];
        a2 = src2[l*AW +: AW];
        ad = dst[l*AW +: AW];
        psrc1[l*PW +: PW] = dep_break[l] ? '0 : work[a1];
        psrc2[l*PW +: PW] = dep_break[l] ? '0 : work[a2];
        pold[l*PW +: PW]  = work[ad];
        pold_vld[l]       = (work[ad] != '0);
        nt                = zero_idiom[l] ? '0 : alloc_tag[l*PW +: PW];
        pdst[l*PW +: PW]  = nt;
        work[ad]          = nt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_REGS; a++) map_q[a] <= PW'(a + 1);
    end else if (commit) begin
      for (int a = 0; a < ARCH_REGS; a++) map_q[a] <= work[a];
    end
  end
endmodule

// File: rtl/rename_zero_stage.sv
module rename_zero_stage #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 24,
  parameter int LANES     = 4,
  localparam int AW       = $clog2(ARCH_REGS),
  localparam int PW       = $clog2(PHYS_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    in_lane_vld,
  input  logic [LANES*2-1:0]  in_op,
  input  logic [LANES*AW-1:0] in_src1,
  input  logic [LANES*AW-1:0] in_src2,
  input  logic [LANES*AW-1:0] in_dst,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES-1:0]    out_lane_vld,
  output logic [LANES-1:0]    out_elim,
  output logic [LANES*PW-1:0] out_psrc1,
  output logic [LANES*PW-1:0] out_psrc2,
  output logic [LANES*PW-1:0] out_pdst,
  output logic [LANES*PW-1:0] out_pold,
  output logic [LANES-1:0]    out_pold_vld,
  input  logic [LANES-1:0]    rel_vld,
  input  logic [LANES*PW-1:0] rel_tag
);
  logic [LANES-1:0]    zero_idiom, dep_break, need_alloc;
  logic [LANES*PW-1:0] alloc_tag;
  logic                alloc_ok;
  logic                accept;
  logic [LANES*PW-1:0] m_psrc1, m_psrc2, m_pdst, m_pold;
  logic [LANES-1:0]    m_pold_vld;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rn_idiom #(.AW(AW)) u_idiom (
      .vld        (in_lane_vld[l]),
      .op         (in_op[l*2 +: 2]),
      .s1         (in_src1[l*AW +: AW]),
      .s2         (in_src2[l*AW +: AW]),
      .zero_idiom (zero_idiom[l]),
      .dep_break  (dep_break[l]),
      .need_alloc (need_alloc[l])
    );
  end

  assign in_ready = (!out_valid || out_ready) && alloc_ok;
  assign accept   = in_valid && in_ready;

  rn_freelist #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .LANES(LANES), .PW(PW)
  ) u_free (
    .clk(clk), .rst_n(rst_n), .need(need_alloc), .commit(accept),
    .rel_vld(rel_vld), .rel_tag(rel_tag),
    .alloc_tag(alloc_tag), .alloc_ok(alloc_ok)
  );

  rn_map #(
    .ARCH_REGS(ARCH_REGS), .LANES(LANES), .AW(AW), .PW(PW)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .commit(accept),
    .lane_vld(in_lane_vld), .src1(in_src1), .src2(in_src2), .dst(in_dst),
    .zero_idiom(zero_idiom), .dep_break(dep_break), .alloc_tag(alloc_tag),
    .psrc1(m_psrc1), .psrc2(m_psrc2), .pdst(m_pdst),
    .pold(m_pold), .pold_vld(m_pold_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_lane_vld <= '0;
      out_elim     <= '0;
      out_psrc1    <= '0;
      out_psrc2    <= '0;
      out_pdst     <= '0;
      out_pold     <= '0;
      out_pold_vld <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_lane_vld <= in_lane_vld;
      out_elim     <= zero_idiom;
      out_psrc1    <= m_psrc1;
      out_psrc2    <= m_psrc2;
      out_pdst     <= m_pdst;
      out_pold     <= m_pold;
      out_pold_vld <= m_pold_vld;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int LANES = 4,
  parameter int PW    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES-1:0]    out_lane_vld,
  input logic [LANES-1:0]    out_elim,
  input logic [LANES*PW-1:0] out_psrc1,
  input logic [LANES*PW-1:0] out_pdst
);
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_no_zero_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_lane_vld[l] && !out_elim[l]) |-> (out_pdst[l*PW +: PW] != '0))
      else $error("zero register handed out on lane %0d", l);

    assert_elim_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_lane_vld[l] && out_elim[l]) |->
        (out_pdst[l*PW +: PW] == '0 && out_psrc1[l*PW +: PW] == '0))
      else $error("eliminated lane %0d not mapped to zero", l);

    for (genvar m = l + 1; m < LANES; m++) begin : g_pair
      assert_distinct_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_lane_vld[l] && out_lane_vld[m] && !out_elim[l] && !out_elim[m])
          |-> (out_pdst[l*PW +: PW] != out_pdst[m*PW +: PW]))
        else $error("lanes %0d and %0d share a destination", l, m);
    end
  end

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pdst) && $stable(out_lane_vld)))
    else $error("output group changed while stalled");

  assert_block_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("input taken while output stalled");
endmodule

bind rename_zero_stage rn_checker #(.LANES(LANES), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_lane_vld(out_lane_vld), .out_elim(out_elim),
  .out_psrc1(out_psrc1), .out_pdst(out_pdst)
);

// File: tb/rename_zero_stage_tb.sv
module rename_zero_stage_tb;
  localparam int NA = 8, NP = 24, NL = 4, AW = 3, PW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [NL-1:0] in_lane_vld = '0, rel_vld = '0;
  logic [NL*2-1:0] in_op = '0;
  logic [NL*AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [NL-1:0] out_lane_vld, out_elim, out_pold_vld;
  logic [NL*PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold, rel_tag = '0;

  always #2 clk = ~clk;

  rename_zero_stage #(.ARCH_REGS(NA), .PHYS_REGS(NP), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane_vld(in_lane_vld), .in_op(in_op), .in_src1(in_src1),
    .in_src2(in_src2), .in_dst(in_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_lane_vld(out_lane_vld), .out_elim(out_elim),
    .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_pdst(out_pdst),
    .out_pold(out_pold), .out_pold_vld(out_pold_vld),
    .rel_vld(rel_vld), .rel_tag(rel_tag)
  );

  int n_tests = 0, n_fail = 0;
  int mmap[NA];
  logic [NP-1:0] mfree;
  int relq[$];
  bit lv[NL];
  int op[NL], s1[NL], s2[NL], d[NL];
  bit out_held = 0;
  int stalls = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int p = 1; p < NP; p++) if (mfree[p]) return p;
    return -1;
  endfunction

  task automatic send_group();
    int need, avail, ept, es1, es2;
    bit zero, brk;
    bit [NA-1:0] written;
    logic [NL*PW-1:0] prev_pdst;
    string tag;
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      in_lane_vld[l]        = lv[l];
      in_op[l*2 +: 2]       = 2'(op[l]);
      in_src1[l*AW +: AW]   = 3'(s1[l]);
      in_src2[l*AW +: AW]   = 3'(s2[l]);
      in_dst[l*AW +: AW]    = 3'(d[l]);
    end
    in_valid = 1'b1;
    #1;
    need = 0;
    for (int l = 0; l < NL; l++)
      if (lv[l] && !((op[l] == 1 || op[l] == 2) && s1[l] == s2[l])) need++;
    avail = $countones(mfree);
    if (out_held || need > avail) begin
      chk(out_held ? "R9" : "R8", "in_ready on stall", int'(in_ready), 0);
      prev_pdst = out_pdst;
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (out_held) begin
        chk("R9", "out_valid held", int'(out_valid), 1);
        chk("R9", "out_pdst held", int'(out_pdst), int'(prev_pdst));
      end else stalls++;
      return;
    end
    chk("R8", "in_ready with room", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R9", "out_valid after accept", int'(out_valid), 1);
    written = '0;
    for (int l = 0; l < NL; l++) begin
      if (!lv[l]) begin
        chk("R11", "idle lane valid", int'(out_lane_vld[l]), 0);
        continue;
      end
      zero = (op[l] == 1 || op[l] == 2) && s1[l] == s2[l];
      brk  = (op[l] != 0) && s1[l] == s2[l];
      es1  = brk ? 0 : mmap[s1[l]];
      es2  = brk ? 0 : mmap[s2[l]];
      if (zero) tag = "R2";
      else if (op[l] == 3 && brk) tag = "R4";
      else if (op[l] == 0 && s1[l] == s2[l]) tag = "R3";
      else if (written[s1[l]] || written[s2[l]]) tag = "R6";
      else tag = "R5";
      chk(tag, "lane valid", int'(out_lane_vld[l]), 1);
      chk(tag, "elim", int'(out_elim[l]), int'(zero));
      chk(tag, "psrc1", int'(out_psrc1[l*PW +: PW]), es1);
      chk(tag, "psrc2", int'(out_psrc2[l*PW +: PW]), es2);
      chk("R7", "pold", int'(out_pold[l*PW +: PW]), mmap[d[l]]);
      chk("R7", "pold_vld", int'(out_pold_vld[l]), int'(mmap[d[l]] != 0));
      if (mmap[d[l]] != 0) relq.push_back(mmap[d[l]]);
      if (zero) ept = 0;
      else begin
        ept = lowest_free();
        mfree[ept] = 1'b0;
      end
      chk(zero ? "R2" : "R5", "pdst", int'(out_pdst[l*PW +: PW]), ept);
      mmap[d[l]] = ept;
      written[d[l]] = 1'b1;
    end
  endtask

  // R10: hands back queued tags, optionally with an extra tag 0 that must be ignored
  task automatic release_all(input bit with_zero);
    while (relq.size() > 0 || with_zero) begin
      @(negedge clk);
      rel_vld = '0;
      for (int l = 0; l < NL; l++) begin
        if (with_zero && l == NL - 1) begin
          rel_vld[l] = 1'b1;
          rel_tag[l*PW +: PW] = '0;
        end else if (relq.size() > 0) begin
          int t;
          t = relq.pop_front();
          rel_vld[l] = 1'b1;
          rel_tag[l*PW +: PW] = 5'(t);
          mfree[t] = 1'b1;
        end
      end
      with_zero = 0;
      @(posedge clk); #1;
      rel_vld = '0;
    end
  endtask

  task automatic set_lane(input int l, input bit v, input int o, input int a, input int b, input int c);
    lv[l] = v; op[l] = o; s1[l] = a; s2[l] = b; d[l] = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) mmap[a] = a + 1;
    for (int p = 0; p < NP; p++) mfree[p] = (p > NA);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);

    // R1/R5: reads of the reset map and first allocations
    set_lane(0, 1, 0, 0, 1, 4); set_lane(1, 1, 0, 2, 3, 5);
    set_lane(2, 1, 0, 6, 7, 6); set_lane(3, 0, 0, 0, 0, 0);
    send_group();

    // R6/R2/R3/R4: zero remap seen by later lanes
    set_lane(0, 1, 2, 1, 1, 1); set_lane(1, 1, 0, 1, 1, 2);
    set_lane(2, 1, 1, 2, 2, 2); set_lane(3, 1, 3, 2, 2, 3);
    send_group();
    release_all(1);

    // R9: output back-pressure
    out_ready = 1'b0;
    set_lane(0, 1, 0, 3, 4, 5); set_lane(1, 1, 2, 6, 6, 7);
    set_lane(2, 0, 0, 0, 0, 0); set_lane(3, 1, 0, 5, 7, 0);
    send_group();
    out_held = 1;
    send_group();
    out_held = 0;
    out_ready = 1'b1;
    @(negedge clk);
    send_group();
    release_all(0);

    // R8: exhaust the free list without releasing
    for (int g = 0; g < 8 && stalls == 0; g++) begin
      for (int l = 0; l < NL; l++) set_lane(l, 1, 0, (g + l) % NA, (g * 3 + l) % NA, (l * 2 + g) % NA);
      send_group();
    end
    chk("R8", "stall reached", int'(stalls > 0), 1);
    release_all(0);
    // table must be unchanged by the stalled group: psrcs checked against model
    for (int l = 0; l < NL; l++) set_lane(l, 1, 0, l, l + 4, l);
    send_group();
    release_all(0);

    // sweep over classes, equal/unequal sources and lane masks
    for (int g = 0; g < 400; g++) begin
      for (int l = 0; l < NL; l++) begin
        int k;
        k = g * NL + l;
        set_lane(l, (k % 11) != 0, k % 4, (k * 3) % NA,
                 (((k >> 2) & 1) != 0) ? (k * 3) % NA : (k * 5 + 1) % NA, (k * 7 + g) % NA);
      end
      send_group();
      if (g % 3 == 2) release_all(0);
    end
    release_all(0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule